// File: doc/BRIEF.md
# Out-of-Frame SPI Register Transactor

This block is an SPI master that turns single register requests into 32-bit serial frames for a sensor. The sensor answers each frame during the following frame. A read therefore costs two frames: first the request, then a frame that sends all zeros and collects the answer. A write costs one frame and expects no answer.

Each outgoing frame carries a 3-bit serial CRC in its lowest bits. Each answer is accepted only when its CRC checks out and its two status bits are not both set. The master drives the serial clock in mode 0 from a divided system clock. It also holds chip select high for a guaranteed minimum time between frames.

The user side has a valid/ready request channel and a valid/ready response channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle, so while a transaction runs a held or pulsed `req_valid` has no effect. Only reads produce a response. The response stays on the port, unchanged, until `rsp_ready` is high on a clock edge. Until that handshake the block stays busy and refuses new requests.

Top module: `oof_spi_xactor`

## Requirements
- R1: Every frame is exactly 32 serial clock pulses and is sent MSB first. The request word is laid out as follows:
  - bits 31:30 are 0;
  - bits 29:22 hold the address;
  - bit 21 is the write flag;
  - bit 20 is the capture flag;
  - bits 18:3 hold the write data on writes and are 0 on reads;
  - bits 19 and 2:0 are 0 before the CRC is inserted.
- R2: Bits 2:0 of the request hold a CRC run over the word with those bits at zero. The CRC state starts at 3'b101 and takes in one bit per step, MSB first. Each step saves state bit 2, shifts the state left, puts the frame bit into bit 0, XORs the state with 3'b011 when the saved bit was 1, and keeps 3 bits.
- R3: A read sends the request frame and then a second frame whose MOSI bits are all 0. The word received during the second frame is the answer, and its bits 19:4 appear on `rsp_rdata`. The word received during the first frame is ignored.
- R4: `rsp_err` is 1 when the CRC of R2, run over all 32 received bits, does not end at 0.
- R5: `rsp_err` is 1 when received bits 31 and 3 are both 1. A word with only one of these bits set and a good CRC is accepted with `rsp_err` = 0.
- R6: A write is one frame with bit 21 set. It produces no response, and `busy` falls after that frame and its deselect gap.
- R7: The serial interface works in mode 0:
  - SCLK is low whenever chip select is high;
  - MOSI changes only while SCLK is low;
  - MISO is sampled on the rising edge;
  - each SCLK phase lasts `SCLK_HALF` system cycles.
- R8: Chip select stays high for at least floor(`MIN_GAP_NS`·`CLK_MHZ`/1000)+1 system cycles between frames.
- R9: `req_ready` is low while `busy` is high, and a request presented during that time starts no frame.
- R10: A response is held stable with `rsp_valid` high until `rsp_ready`. Until then no request is accepted.
- R11: During reset, `spi_cs_n` = 1, `spi_sclk` = 0, `busy` = 0 and `rsp_valid` = 0. After reset, `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 8 | Register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_capture | input | 1 | Capture flag placed in bit 20 |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read data from answer bits 19:4 |
| rsp_err | output | 1 | Answer failed CRC or status check |
| busy | output | 1 | Transaction in progress or response pending |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The hardest case to reach is a read in which the two frames carry different answers. Only the second answer may reach the response port. A wrong frame pairing would otherwise pass unnoticed.

The bench's sensor model returns an all-ones word on the first frame of every read. That word is invalid in both status bits. The model returns the prepared answer only on the second frame.

Status-bit and CRC errors are built with a correct or a deliberately broken CRC from the bench's own CRC routine. A held response with a competing request forces the back-pressure path.

// File: rtl/oof_pkg.sv
package oof_pkg;
  localparam int FRAME_W = 32;
  localparam logic [2:0] CRC_SEED = 3'b101;
  localparam logic [2:0] CRC_POLY = 3'b011;

  typedef enum logic [1:0] {FS_IDLE, FS_LOW, FS_HIGH, FS_GAP} fs_state_e;
  typedef enum logic [2:0] {X_IDLE, X_F1, X_W1, X_F2, X_W2, X_RSP} xact_state_e;

  // one serial CRC step: shift the frame bit in at the bottom, fold back on carry-out
  function automatic logic [2:0] crc3_step(logic [2:0] s, logic b);
    logic [2:0] n;
    n = {s[1:0], b};
    if (s[2]) n = n ^ CRC_POLY;
    return n;
  endfunction

  function automatic logic [2:0] crc3_word(logic [FRAME_W-1:0] w);
    logic [2:0] s;
    s = CRC_SEED;
    for (int i = FRAME_W - 1; i >= 0; i--) s = crc3_step(s, w[i]);
    return s;
  endfunction
endpackage

// File: rtl/oof_clk_div.sv
module oof_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (!en)                    cnt <= '0;
    else if (cnt == CW'(HALF - 1))   cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/oof_gap_timer.sv
module oof_gap_timer #(
  parameter int CYC = 71
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_GAP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired); // R8
endmodule

// File: rtl/oof_rx_check.sv
module oof_rx_check
  import oof_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        bit_valid,
  input  logic        bit_val,
  output logic [15:0] rx_data,
  output logic        status_both,
  output logic        crc_zero
);
  logic [FRAME_W-1:0] sr;
  logic [2:0]         crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc <= CRC_SEED;
      sr  <= '0;
    end else if (clear) begin
      crc <= CRC_SEED;
      sr  <= '0;
    end else if (bit_valid) begin
      crc <= crc3_step(crc, bit_val);
      sr  <= {sr[FRAME_W-2:0], bit_val};
    end
  end

  assign rx_data     = sr[19:4];
  assign status_both = sr[31] & sr[3];
  assign crc_zero    = (crc == 3'b000);
endmodule

// File: rtl/oof_frame_shifter.sv
module oof_frame_shifter
  import oof_pkg::*;
#(
  parameter int SCLK_HALF = 2,
  parameter int GAP_CYC   = 71
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               idle,
  output logic               done,
  output logic               bit_valid,
  output logic               bit_val,
  output logic               spi_sclk,
  output logic               spi_mosi,
  output logic               spi_cs_n,
  input  logic               spi_miso
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int HC_W  = $clog2(GAP_CYC + 1);

  fs_state_e          st;
  logic [FRAME_W-1:0] txsr;
  logic [BIT_W-1:0]   bitcnt;
  logic               tick, div_en, gap_load, gap_expired;

  assign div_en   = (st == FS_LOW) || (st == FS_HIGH);
  assign gap_load = (st == FS_HIGH) && tick && (bitcnt == BIT_W'(FRAME_W - 1));

  oof_clk_div #(.HALF(SCLK_HALF)) u_div (
    .clk (clk), .rst_n (rst_n), .en (div_en), .tick (tick)
  );

  oof_gap_timer #(.CYC(GAP_CYC)) u_gap (
    .clk (clk), .rst_n (rst_n), .load (gap_load), .expired (gap_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FS_IDLE;
      txsr     <= '0;
      bitcnt   <= '0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
    end else begin
      unique case (st)
        FS_IDLE: if (start) begin
          txsr     <= tx_word;
          bitcnt   <= '0;
          spi_cs_n <= 1'b0;
          st       <= FS_LOW;
        end
        FS_LOW: if (tick) begin
          spi_sclk <= 1'b1;
          st       <= FS_HIGH;
        end
        FS_HIGH: if (tick) begin
          spi_sclk <= 1'b0;
          if (gap_load) begin
            spi_cs_n <= 1'b1;
            st       <= FS_GAP;
          end else begin
            txsr   <= {txsr[FRAME_W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
            st     <= FS_LOW;
          end
        end
        FS_GAP: if (gap_expired) st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign spi_mosi  = !spi_cs_n && txsr[FRAME_W-1];
  assign idle      = (st == FS_IDLE);
  assign done      = (st == FS_GAP) && gap_expired;
  assign bit_valid = (st == FS_LOW) && tick;
  assign bit_val   = spi_miso;

  // checking-only counters: deselect length and rising edges per frame
  logic [HC_W-1:0] hi_cnt;
  logic [BIT_W:0]  rise_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= HC_W'(GAP_CYC);
      rise_cnt <= '0;
    end else begin
      if (!spi_cs_n)                   hi_cnt <= '0;
      else if (hi_cnt != HC_W'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
      if (spi_cs_n)                    rise_cnt <= '0;
      else if (bit_valid)              rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R7
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi)); // R7
  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= HC_W'(GAP_CYC))); // R8
  AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (rise_cnt == (BIT_W+1)'(FRAME_W))); // R1
endmodule

// File: rtl/oof_spi_xactor.sv
module oof_spi_xactor
  import oof_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int MIN_GAP_NS = 700,
  parameter int SCLK_HALF  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_addr,
  input  logic        req_write,
  input  logic [15:0] req_wdata,
  input  logic        req_capture,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        busy,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso
);
  // strictly more than the minimum: floor plus one cycle
  localparam int GAP_CYC = (MIN_GAP_NS * CLK_MHZ) / 1000 + 1;

  xact_state_e        st;
  logic [FRAME_W-1:0] body, req_frame, tx_hold, fs_tx;
  logic               is_wr, fs_start, fs_idle, fs_done, bit_valid, bit_val;
  logic [15:0]        rx_data;
  logic               status_both, crc_zero;

  always_comb begin
    body        = '0;
    body[29:22] = req_addr;
    body[21]    = req_write;
    body[20]    = req_capture;
    body[18:3]  = req_write ? req_wdata : 16'h0000;
  end
  assign req_frame = {body[FRAME_W-1:3], crc3_word(body)};

  assign fs_start = (st == X_F1) || (st == X_F2);
  assign fs_tx    = (st == X_F2) ? '0 : tx_hold;

  oof_frame_shifter #(.SCLK_HALF(SCLK_HALF), .GAP_CYC(GAP_CYC)) u_shift (
    .clk (clk), .rst_n (rst_n), .start (fs_start), .tx_word (fs_tx),
    .idle (fs_idle), .done (fs_done), .bit_valid (bit_valid), .bit_val (bit_val),
    .spi_sclk (spi_sclk), .spi_mosi (spi_mosi), .spi_cs_n (spi_cs_n), .spi_miso (spi_miso)
  );

  oof_rx_check u_rx (
    .clk (clk), .rst_n (rst_n), .clear (fs_start && fs_idle),
    .bit_valid (bit_valid), .bit_val (bit_val),
    .rx_data (rx_data), .status_both (status_both), .crc_zero (crc_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= X_IDLE;
      tx_hold   <= '0;
      is_wr     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (st)
        X_IDLE: if (req_valid) begin
          tx_hold <= req_frame;
          is_wr   <= req_write;
          st      <= X_F1;
        end
        X_F1: if (fs_idle) st <= X_W1;
        X_W1: if (fs_done) st <= is_wr ? X_IDLE : X_F2;
        X_F2: if (fs_idle) st <= X_W2;
        X_W2: if (fs_done) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= rx_data;
          rsp_err   <= !crc_zero || status_both;
          st        <= X_RSP;
        end
        X_RSP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          st        <= X_IDLE;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  assign busy      = (st != X_IDLE);
  assign req_ready = (st == X_IDLE);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10
  AST_RSP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == X_W1 && is_wr && fs_done) |=> (!rsp_valid && !busy)); // R6
endmodule

// File: tb/tb_oof_spi_xactor.sv
module tb_oof_spi_xactor;
  localparam int HALF    = 2;
  localparam int MHZ     = 100;
  localparam int GAPNS   = 700;
  localparam int GAP_EXP = GAPNS * MHZ / 1000 + 1;

  // {write, capture, addr[8], wdata[16], rdata[16], mode[2]}
  // mode: 0 good, 1 broken CRC, 2 both status bits, 3 only bit 31 set
  localparam logic [43:0] VECS [8] = '{
    {1'b0, 1'b0, 8'h11, 16'hABCD, 16'h1234, 2'd0},
    {1'b1, 1'b0, 8'h0A, 16'h0079, 16'h0000, 2'd0},
    {1'b0, 1'b1, 8'h17, 16'h0000, 16'hBEEF, 2'd0},
    {1'b0, 1'b0, 8'h14, 16'h0000, 16'h8001, 2'd1},
    {1'b0, 1'b0, 8'h10, 16'h0000, 16'h7FFE, 2'd2},
    {1'b0, 1'b0, 8'h12, 16'h0000, 16'h5A5A, 2'd3},
    {1'b1, 1'b1, 8'h2F, 16'h00B6, 16'h0000, 2'd0},
    {1'b0, 1'b0, 8'hFF, 16'h0000, 16'hFFFF, 2'd0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;  // 10-unit period: 100 MHz

  logic rst_n, req_valid, req_ready, req_write, req_capture;
  logic rsp_valid, rsp_ready, rsp_err, busy;
  logic spi_sclk, spi_mosi, spi_cs_n, spi_miso;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata, rsp_rdata;

  oof_spi_xactor #(.CLK_MHZ(MHZ), .MIN_GAP_NS(GAPNS), .SCLK_HALF(HALF)) dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_write (req_write), .req_wdata (req_wdata),
    .req_capture (req_capture), .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata), .rsp_err (rsp_err), .busy (busy), .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi), .spi_cs_n (spi_cs_n), .spi_miso (spi_miso)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_crc(input logic [31:0] w);
    int r;
    int carry;
    r = 5;
    for (int i = 31; i >= 0; i--) begin
      carry = (r >> 2) & 1;
      r = ((r << 1) | int'(w[i])) & 7;
      if (carry != 0) r = r ^ 3;
    end
    return 3'(r);
  endfunction

  // ---------------- sensor model, sampled between clock edges ----------------
  logic [31:0] w0 = '1, w1 = '0, shreg = '0, cap = '0;
  logic [31:0] frames [64];
  int ftx = 0, nfr = 0, nbits = 0, hicnt = 0, hi_len = 0;
  int min_gap = 1000000, halfbad = 0, mosi_moved = 0, bitbad = 0, rsp_seen = 0;
  logic pcs = 1'b1, psclk = 1'b0, mrise = 1'b0, first = 1'b1;

  assign spi_miso = shreg[31];

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (pcs && !spi_cs_n) begin
        if (!first && hicnt < min_gap) min_gap = hicnt;
        first = 1'b0;
        shreg = (ftx == 0) ? w0 : w1;
        ftx++;
        cap = '0;
        nbits = 0;
      end
      if (!spi_cs_n && !psclk && spi_sclk) begin
        cap = {cap[30:0], spi_mosi};
        nbits++;
        mrise = spi_mosi;
        hi_len = 1;
      end else if (spi_sclk) begin
        hi_len++;
        if (spi_mosi !== mrise) mosi_moved++;
      end
      if (!spi_cs_n && psclk && !spi_sclk) begin
        if (hi_len != HALF) halfbad++;
        shreg = {shreg[30:0], 1'b0};
      end
      if (!pcs && spi_cs_n && nbits > 0) begin
        if (nfr < 64) frames[nfr] = cap;
        if (nbits != 32) bitbad++;
        nfr++;
      end
      if (spi_cs_n) hicnt++;
      else          hicnt = 0;
      if (rsp_valid) rsp_seen++;
      pcs   = spi_cs_n;
      psclk = spi_sclk;
    end
  end

  function automatic logic [31:0] build_req(input logic wr, input logic cp,
                                            input logic [7:0] a, input logic [15:0] d);
    logic [31:0] w;
    w = {2'b00, a, wr, cp, 1'b0, (wr ? d : 16'h0000), 3'b000};
    w[2:0] = ref_crc(w);
    return w;
  endfunction

  function automatic logic [31:0] build_rsp(input logic [15:0] d, input logic [1:0] mode);
    logic [31:0] w;
    w = {(mode == 2'd2 || mode == 2'd3), 11'h000, d, (mode == 2'd2), 3'b000};
    w[2:0] = ref_crc(w);
    if (mode == 2'd1) w[0] = ~w[0];
    return w;
  endfunction

  task automatic wait_until_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  task automatic wait_rsp(input int limit);
    for (int i = 0; i < limit && !rsp_valid; i++) @(negedge clk);
  endtask

  task automatic run_xact(input logic [43:0] v);
    logic        wr, cp, exp_err;
    logic [7:0]  a;
    logic [15:0] d, rd;
    logic [1:0]  mode;
    logic [31:0] exp_req;
    int f0, s0;
    {wr, cp, a, d, rd, mode} = v;
    exp_req = build_req(wr, cp, a, d);
    exp_err = (mode == 2'd1) || (mode == 2'd2);
    w0 = 32'hFFFF_FFFF;
    w1 = build_rsp(rd, mode);
    ftx = 0;
    f0 = nfr;
    s0 = rsp_seen;
    req_valid = 1'b1; req_write = wr; req_capture = cp; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && req_ready === 1'b0, "R9", "busy after accept", {busy, req_ready}, 2'b10);
    if (wr) begin
      wait_until_idle(2000);
      chk(nfr - f0 == 1, "R6", "frames per write", nfr - f0, 1);
      chk(frames[f0] === exp_req, "R1/R2", "write request word", frames[f0], exp_req);
      chk(rsp_seen == s0, "R6", "write gave response", rsp_seen - s0, 0);
    end else begin
      wait_rsp(2000);
      chk(rsp_valid === 1'b1, "R3", "read response arrived", rsp_valid, 1);
      chk(nfr - f0 == 2, "R3", "frames per read", nfr - f0, 2);
      chk(frames[f0] === exp_req, "R1/R2", "read request word", frames[f0], exp_req);
      chk(frames[f0+1] === 32'h0, "R3", "second frame MOSI", frames[f0+1], 0);
      chk(rsp_err === exp_err, (mode == 2'd1) ? "R4" : "R5", "error flag", rsp_err, exp_err);
      if (!exp_err) chk(rsp_rdata === rd, "R3", "read data", rsp_rdata, rd);
      @(negedge clk);
      chk(rsp_valid === 1'b0 && busy === 1'b0, "R10", "released after handshake",
          {rsp_valid, busy}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0, s0;
    logic [15:0] held;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_capture = 1'b0;
    req_addr = '0; req_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R11", "reset pins", {spi_cs_n, spi_sclk}, 2'b10);
    chk(busy === 1'b0 && rsp_valid === 1'b0, "R11", "reset status", {busy, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready after reset", req_ready, 1);

    for (int k = 0; k < 8; k++) run_xact(VECS[k]);

    // R9: requests offered during a running write start nothing
    f0 = nfr; s0 = rsp_seen;
    w0 = '1; ftx = 0;
    req_valid = 1'b1; req_write = 1'b1; req_capture = 1'b0; req_addr = 8'h0B; req_wdata = 16'h0003;
    @(negedge clk);
    req_write = 1'b0; req_addr = 8'h44;
    repeat (20) begin
      chk(req_ready === 1'b0, "R9", "ready while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_until_idle(2000);
    repeat (200) @(negedge clk);
    chk(nfr - f0 == 1, "R9", "frames after busy offers", nfr - f0, 1);
    chk(rsp_seen == s0, "R9", "responses after busy offers", rsp_seen - s0, 0);

    // R10: back-pressure holds the response and blocks requests
    rsp_ready = 1'b0;
    w0 = '1; w1 = build_rsp(16'hC3C3, 2'd0); ftx = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h15;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(2000);
    held = rsp_rdata;
    chk(held === 16'hC3C3, "R10", "held data", held, 16'hC3C3);
    f0 = nfr;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h66; req_wdata = 16'h1111;
    repeat (10) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_rdata === held && req_ready === 1'b0, "R10",
          "stall hold", {rsp_valid, req_ready, rsp_rdata}, {2'b10, held});
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10", "valid drops on ready", rsp_valid, 0);
    repeat (300) @(negedge clk);
    chk(nfr == f0 && busy === 1'b0, "R10", "stalled request ignored", nfr - f0, 0);

    chk(min_gap >= GAP_EXP, "R8", "minimum deselect cycles", min_gap, GAP_EXP);
    chk(halfbad == 0, "R7", "SCLK high phase length errors", halfbad, 0);
    chk(mosi_moved == 0, "R7", "MOSI changes while SCLK high", mosi_moved, 0);
    chk(bitbad == 0, "R1", "frames not 32 bits", bitbad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule